// File: doc/BRIEF.md
# PWM Pair ADC Trigger Selector

This block turns the timing events of one pair of PWM channels into a start-of-conversion strobe for an analog-to-digital converter. The pair has an even and an odd channel. Each channel reports strobes for its counter reaching zero, reaching its period and matching its duty comparator, together with its current count direction. The even channel also supplies its counter value. A 4-bit source code picks which of these conditions produces the strobe. The choices cover zero, period, zero-or-period, and up-counting or down-counting compare matches on either channel. Two more codes use a separate 16-bit free-trigger comparator on the even channel's counter, qualified by count direction.

The free-trigger value is written into a holding register. It becomes the active compare value only at the next period event of the even channel, so a new value never cuts into a running period. Every strobe also sets a sticky flag that software reads and clears by writing a one. A global enable gates the strobe. Source codes 12 to 15 are reserved for the free-trigger comparators of other channel pairs and produce nothing in this single-pair instance.

Top module: `pwm_pair_adc_trig`

## Requirements
- R1: Source codes 0, 1, 2, 3 and 4 select the even channel's zero strobe, period strobe, zero-or-period strobe, compare strobe while counting up (direction input 1), and compare strobe while counting down (direction input 0).
- R2: Source codes 5 to 9 select the same five conditions, in the same order, from the odd channel.
- R3: Source code 10 fires when the even counter equals the active free-trigger value while the even direction is up. Code 11 fires on the same equality while the direction is down.
- R4: Source codes 12 to 15 never produce a strobe or set the flag, whatever the events.
- R5: A write puts a 16-bit free-trigger value into a holding register. The active compare value loads from the holding register only in a cycle with an even-channel period strobe.
- R6: The strobe `adc_soc` is registered. It is high for exactly the one cycle after each cycle in which the selected condition is true and the enable is high.
- R7: While `soc_en` is low, no strobe is produced and the flag is not set.
- R8: Each strobe sets `soc_flag` in the same cycle. The flag stays set until it is cleared.
- R9: A one on `flag_clr` clears the flag in the next cycle. If a new strobe occurs in that same cycle, the flag stays set.
- R10: After the synchronous reset, the strobe and the flag are low and both free-trigger registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soc_en | input | 1 | Strobe enable |
| src_sel | input | 4 | Trigger source code |
| ev_zero_even | input | 1 | Even channel counter-at-zero strobe |
| ev_prd_even | input | 1 | Even channel counter-at-period strobe |
| ev_cmp_even | input | 1 | Even channel compare-match strobe |
| up_even | input | 1 | Even channel direction, 1 = counting up |
| ev_zero_odd | input | 1 | Odd channel counter-at-zero strobe |
| ev_prd_odd | input | 1 | Odd channel counter-at-period strobe |
| ev_cmp_odd | input | 1 | Odd channel compare-match strobe |
| up_odd | input | 1 | Odd channel direction, 1 = counting up |
| cnt_even | input | 16 | Even channel counter value |
| ftc_wr | input | 1 | Write strobe for the free-trigger holding register |
| ftc_wdata | input | 16 | Free-trigger value to write |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| adc_soc | output | 1 | Start-of-conversion strobe |
| soc_flag | output | 1 | Sticky trigger flag |

## Verification
The strobe and the flag both come out one cycle after the inputs that cause them. The bench therefore drives inputs at a falling edge and checks both outputs at the next falling edge, after exactly one rising edge. A free-trigger write needs one edge to reach the holding register and a period strobe at a later edge to become active, so each free-trigger check follows those two steps.

The sweep covers every source code against every combination of event strobes, directions and counter match. `flag_clr` is held high throughout the sweep, so the flag must equal that cycle's strobe. The sticky, clear-collision, enable and next-period-load checks are short directed sequences sampled cycle by cycle.

// File: rtl/pwm_adc_trig_pkg.sv
package pwm_adc_trig_pkg;
  // Per-channel event bundle
  typedef struct packed {
    logic zero;
    logic prd;
    logic cmp;
    logic up;
  } chan_ev_t;

  // Conditions per channel: zero, period, zero|period, cmp up, cmp down
  localparam int unsigned COND_PER_CH = 5;
  localparam int unsigned CH_PER_PAIR = 2;
  localparam logic [3:0]  SRC_FT_UP   = 4'd10;
  localparam logic [3:0]  SRC_FT_DN   = 4'd11;
endpackage

// File: rtl/pwm_ftc_cmp.sv
module pwm_ftc_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             prd_evt,
  input  logic             up,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit_up,
  output logic             hit_dn
);
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] act_q;
  logic             eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr)      hold_q <= wdata;
      if (prd_evt) act_q  <= hold_q;
    end
  end

  assign eq     = (cnt == act_q);
  assign hit_up = eq & up;
  assign hit_dn = eq & ~up;

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !prd_evt |=> $stable(act_q));
endmodule

// File: rtl/pwm_trig_mux.sv
module pwm_trig_mux
  import pwm_adc_trig_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0]            sel,
  input  chan_ev_t [CH_PER_PAIR-1:0]  ev,
  input  logic                        ft_up,
  input  logic                        ft_dn,
  output logic                        hit
);
  localparam int unsigned SRC_N  = 2 ** SEL_W;
  localparam int unsigned CH_SRC = COND_PER_CH * CH_PER_PAIR;
  localparam int unsigned PAD_N  = SRC_N - CH_SRC - 2;

  logic [CH_SRC-1:0] ch_vec;
  logic [SRC_N-1:0]  src_vec;

  for (genvar c = 0; c < CH_PER_PAIR; c++) begin : g_ch
    assign ch_vec[c*COND_PER_CH +: COND_PER_CH] = {
      ev[c].cmp & ~ev[c].up,
      ev[c].cmp &  ev[c].up,
      ev[c].zero | ev[c].prd,
      ev[c].prd,
      ev[c].zero
    };
  end

  // Codes above the free-trigger pair belong to other pairs: tied low here
  assign src_vec = {{PAD_N{1'b0}}, ft_dn, ft_up, ch_vec};
  assign hit     = src_vec[sel];

  initial begin
    ft_code_chk: assert (int'(SRC_FT_UP) == CH_SRC && int'(SRC_FT_DN) == CH_SRC + 1);
  end
endmodule

// File: rtl/pwm_pair_adc_trig.sv
module pwm_pair_adc_trig
  import pwm_adc_trig_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soc_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             ev_zero_even,
  input  logic             ev_prd_even,
  input  logic             ev_cmp_even,
  input  logic             up_even,
  input  logic             ev_zero_odd,
  input  logic             ev_prd_odd,
  input  logic             ev_cmp_odd,
  input  logic             up_odd,
  input  logic [CNT_W-1:0] cnt_even,
  input  logic             ftc_wr,
  input  logic [CNT_W-1:0] ftc_wdata,
  input  logic             flag_clr,
  output logic             adc_soc,
  output logic             soc_flag
);
  chan_ev_t [CH_PER_PAIR-1:0] ev;
  logic ft_up, ft_dn, src_hit, fire;

  assign ev[0] = '{zero: ev_zero_even, prd: ev_prd_even, cmp: ev_cmp_even, up: up_even};
  assign ev[1] = '{zero: ev_zero_odd,  prd: ev_prd_odd,  cmp: ev_cmp_odd,  up: up_odd};

  pwm_ftc_cmp #(.CNT_W(CNT_W)) u_ftc (
    .clk(clk), .rst(rst), .wr(ftc_wr), .wdata(ftc_wdata),
    .prd_evt(ev_prd_even), .up(up_even), .cnt(cnt_even),
    .hit_up(ft_up), .hit_dn(ft_dn)
  );

  pwm_trig_mux #(.SEL_W(SEL_W)) u_mux (
    .sel(src_sel), .ev(ev), .ft_up(ft_up), .ft_dn(ft_dn), .hit(src_hit)
  );

  assign fire = src_hit & soc_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_soc  <= 1'b0;
      soc_flag <= 1'b0;
    end else begin
      adc_soc  <= fire;
      soc_flag <= (soc_flag & ~flag_clr) | fire;
    end
  end

  // R6
  soc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    src_hit && soc_en |=> adc_soc);
  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !soc_en |=> !adc_soc);
  // R4
  reserved_src_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(src_sel) > int'(SRC_FT_DN)) |=> !adc_soc);
  // R8
  flag_with_soc_chk: assert property (@(posedge clk) disable iff (rst)
    adc_soc |-> soc_flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    soc_flag && !flag_clr |=> soc_flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !src_hit |=> !soc_flag);
endmodule

// File: tb/pwm_pair_adc_trig_test.sv
`timescale 1ns/1ps
module pwm_pair_adc_trig_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soc_en = 1'b0;
  logic [3:0] src_sel = '0;
  logic ev_zero_even = 0, ev_prd_even = 0, ev_cmp_even = 0, up_even = 0;
  logic ev_zero_odd = 0, ev_prd_odd = 0, ev_cmp_odd = 0, up_odd = 0;
  logic [15:0] cnt_even = '0;
  logic ftc_wr = 0;
  logic [15:0] ftc_wdata = '0;
  logic flag_clr = 0;
  logic adc_soc, soc_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [15:0] V1 = 16'h0A5C;
  localparam logic [15:0] V2 = 16'h5678;

  always #2.5 clk = ~clk;

  pwm_pair_adc_trig uut (
    .clk(clk), .rst(rst), .soc_en(soc_en), .src_sel(src_sel),
    .ev_zero_even(ev_zero_even), .ev_prd_even(ev_prd_even),
    .ev_cmp_even(ev_cmp_even), .up_even(up_even),
    .ev_zero_odd(ev_zero_odd), .ev_prd_odd(ev_prd_odd),
    .ev_cmp_odd(ev_cmp_odd), .up_odd(up_odd),
    .cnt_even(cnt_even), .ftc_wr(ftc_wr), .ftc_wdata(ftc_wdata),
    .flag_clr(flag_clr), .adc_soc(adc_soc), .soc_flag(soc_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_zero_even = 0; ev_prd_even = 0; ev_cmp_even = 0;
    ev_zero_odd = 0;  ev_prd_odd = 0;  ev_cmp_odd = 0;
    ftc_wr = 0; flag_clr = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Expected hit from requirement text: bits p = {match, up_o, cmp_o, prd_o, zero_o, up_e, cmp_e, prd_e, zero_e}
  function automatic logic exp_hit(input int s, input logic [8:0] p);
    logic ze, pe, ce, ue, zo, po, co, uo, m;
    {m, uo, co, po, zo, ue, ce, pe, ze} = p;
    case (s)
      0: return ze;
      1: return pe;
      2: return ze | pe;
      3: return ce & ue;
      4: return ce & ~ue;
      5: return zo;
      6: return po;
      7: return zo | po;
      8: return co & uo;
      9: return co & ~uo;
      10: return m & ue;
      11: return m & ~ue;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) step();
    rst = 0;
    step();
    // R10 reset state
    chk("R10 soc after reset", adc_soc, 1'b0);
    chk("R10 flag after reset", soc_flag, 1'b0);
    // R10 active free-trigger value is zero: counter 0 counting up matches
    soc_en = 1; src_sel = 4'd10; up_even = 1; cnt_even = 16'd0; flag_clr = 1;
    step();
    chk("R10 ftc active zero", adc_soc, 1'b1);
    cnt_even = 16'd1;
    step();
    chk("R10 ftc no match", adc_soc, 1'b0);
    chk("R9 flag cleared", soc_flag, 1'b0);

    // Load V1 into holding, then make it active with an even period strobe
    idle(); src_sel = 4'd12; ftc_wr = 1; ftc_wdata = V1;
    step();
    ftc_wr = 0; ev_prd_even = 1;
    step();
    ev_prd_even = 0;
    step();

    // Exhaustive sweep: every source against every event pattern; clear held high
    flag_clr = 1; soc_en = 1;
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 512; p++) begin
        logic [8:0] pv;
        logic e;
        string tag;
        pv = p[8:0];
        src_sel = s[3:0];
        {up_odd, ev_cmp_odd, ev_prd_odd, ev_zero_odd} = pv[7:4];
        {up_even, ev_cmp_even, ev_prd_even, ev_zero_even} = pv[3:0];
        cnt_even = pv[8] ? V1 : (V1 ^ 16'h0001);
        e = exp_hit(s, pv);
        tag = (s < 5) ? "R1 even source" : (s < 10) ? "R2 odd source" :
              (s < 12) ? "R3 free-trigger source" : "R4 reserved source";
        step();
        chk(tag, adc_soc, e);
        chk("R9 flag equals strobe with clear held", soc_flag, e);
      end
    end
    idle();
    step();

    // R7 enable low blocks strobe and flag
    soc_en = 0; src_sel = 4'd0; ev_zero_even = 1;
    step();
    chk("R7 no soc when disabled", adc_soc, 1'b0);
    chk("R7 no flag when disabled", soc_flag, 1'b0);
    idle(); src_sel = 4'd5; ev_zero_odd = 1;
    step();
    chk("R7 no soc when disabled odd", adc_soc, 1'b0);
    idle();

    // R8 sticky flag, R6 one-cycle strobe
    soc_en = 1; src_sel = 4'd2; ev_prd_even = 1;
    step();
    chk("R6 soc one cycle after event", adc_soc, 1'b1);
    chk("R8 flag set with soc", soc_flag, 1'b1);
    idle();
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R6 soc back low", adc_soc, 1'b0);
      chk("R8 flag sticky", soc_flag, 1'b1);
    end
    // R9 clear together with new strobe keeps flag
    flag_clr = 1; ev_zero_even = 1;
    step();
    chk("R9 set wins over clear", soc_flag, 1'b1);
    idle(); flag_clr = 1;
    step();
    chk("R9 clear alone", soc_flag, 1'b0);
    idle();

    // R5 new value waits for the next period
    ftc_wr = 1; ftc_wdata = V2;
    step();
    idle(); src_sel = 4'd10; up_even = 1; cnt_even = V2;
    step();
    chk("R5 held value not active yet", adc_soc, 1'b0);
    cnt_even = V1;
    step();
    chk("R5 old value still active", adc_soc, 1'b1);
    cnt_even = 16'd0; ev_prd_even = 1;
    step();
    chk("R5 period load cycle no match", adc_soc, 1'b0);
    ev_prd_even = 0; cnt_even = V2;
    step();
    chk("R5 new value active after period", adc_soc, 1'b1);
    cnt_even = V1;
    step();
    chk("R5 old value retired", adc_soc, 1'b0);
    // R3 down direction on the new value
    src_sel = 4'd11; up_even = 0; cnt_even = V2;
    step();
    chk("R3 free-trigger down match", adc_soc, 1'b1);
    up_even = 1;
    step();
    chk("R3 down code ignores up match", adc_soc, 1'b0);
    idle();
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule